// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration state for a small set of hardware debug triggers and exposes it to software through a single register read/write port. A pointer register chooses which trigger the control, address and auxiliary registers refer to. Every write to a trigger's control word is cleaned up before it is stored. The type code carried in the written value picks a per-type rule. The rule keeps only the fields this implementation honours, clears everything else, and replaces an illegal access-size code with the "any size" code 0.

The block does no matching and no instruction counting. It keeps the legal state and presents every trigger's control and address words on flat output buses, so that the comparator and counter logic elsewhere can use them directly. A read-only capability word reports which match types are available.

Register addresses on `csrAddr` are: 0 pointer, 1 control, 2 address, 3 auxiliary, 4 capability. Addresses 5 to 7 read as zero and ignore writes. Reads are combinational. Writes take effect at the rising clock edge on which `csrWe` is high.

Top module: `trig_csr_bank`

## Requirements
- R1: A write to the pointer register whose full value is below NTRIG is stored. A write with a value of NTRIG or more is ignored and the old pointer is kept. The pointer reads back zero-extended.
- R2: After reset the pointer is 0. Every control word holds type 2 in its top four bits with all other bits clear. Every address word is 0, and the auxiliary register reads 0.
- R3: On a control write the type comes from bits [XLEN-1:XLEN-4] of the written value. The debug-mode bit (XLEN-5) is always stored as 0. For type 2 only bits 0..4 and 6 survive, plus the size field under R4/R5. Match (10:7), chain (11), action (15:12), timing (18), select (19) and hit (20) are stored as 0.
- R4: Size codes 0, 1, 2, 3 and 5 are legal. Code 4 and codes 6 to 15 are illegal and store as size 0.
- R5: For type 2 the size code is {bits 22:21, bits 17:16} when XLEN is 64. Bits 22:21 are then kept when the code is legal. When XLEN is 32 only bits 17:16 form the code and are kept, and bits 22:21 store as 0.
- R6: For type 6 bits 0..4, 6, 23 and 24 are kept. The 4-bit size code in bits 19:16 is kept when legal and cleared otherwise. All other low bits, including 5, 20 and 22, store as 0.
- R7: For type 3 (instruction count) only bits 6, 7, 9, 23:10, 25 and 26 are kept. Bits 5:0, 8 and 24 store as 0.
- R8: An address write uses the stored type of the selected trigger. It is stored for types 2 and 6 and ignored for type 3.
- R9: Auxiliary register writes are ignored for every trigger, and the register always reads 0.
- R10: The capability register reads 0x44 (bits 2 and 6). Writes to it are ignored.
- R11: A control write naming any type other than 2, 3 or 6 leaves the control and address words of every trigger unchanged.
- R12: `trigCtrl` and `trigAddr` carry trigger i's words in slice [i*XLEN +: XLEN]. A write affects only the selected trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 3 | Register address within the bank |
| csrWe | input | 1 | Write strobe |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Combinational read data |
| trigCtrl | output | NTRIG*XLEN | Stored control word of every trigger |
| trigAddr | output | NTRIG*XLEN | Stored address word of every trigger |

## Verification
The bench sends control words with every droppable field set, including the debug-mode bit. A rule that masks too little shows up as stray bits in the read-back. It walks the size codes on both sides of the legal set (3, 4, 5, 6, 15). A design that keeps illegal codes, or that treats 5 as illegal, then stores the wrong size. It writes pointer values of exactly NTRIG and values that only truncate into range, which catches a width-truncating comparison. Address writes are made after switching the stored type to instruction count, so a design that decodes the type from the write data instead of the stored word stores an address it should drop. A second instance at XLEN 32 shows whether the high size bits are wrongly kept.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;

  localparam logic [2:0] CSR_SELECT = 3'd0;
  localparam logic [2:0] CSR_CTRL   = 3'd1;
  localparam logic [2:0] CSR_ADDR   = 3'd2;
  localparam logic [2:0] CSR_AUX    = 3'd3;
  localparam logic [2:0] CSR_CAPS   = 3'd4;

  localparam logic [3:0] TY_ADDR2 = 4'd2;
  localparam logic [3:0] TY_ICNT  = 4'd3;
  localparam logic [3:0] TY_ADDR6 = 4'd6;

  typedef struct packed {
    logic selWr;
    logic ctrlWr;
    logic addrWr;
  } strobe_t;

  function automatic logic sizeLegal(input logic [3:0] code);
    return (code <= 4'd3) || (code == 4'd5);
  endfunction

endpackage

// File: rtl/trig_legalize.sv
module trig_legalize
  import trig_csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] wrVal,
  output logic [XLEN-1:0] legal,
  output logic            typeOk
);
  localparam int TYPE_LSB = XLEN - 4;

  logic [3:0] wrType;
  logic [3:0] size2Code;
  logic       unusedBits;

  assign wrType     = wrVal[XLEN-1:TYPE_LSB];
  assign unusedBits = ^wrVal;

  generate
    if (XLEN == 64) begin : g_wide
      assign size2Code = {wrVal[22:21], wrVal[17:16]};
    end else begin : g_narrow
      assign size2Code = {2'b00, wrVal[17:16]};
    end
  endgenerate

  always_comb begin
    legal = '0;
    legal[XLEN-1:TYPE_LSB] = wrType;
    typeOk = 1'b1;
    case (wrType)
      TY_ADDR2: begin
        legal[4:0] = wrVal[4:0];
        legal[6]   = wrVal[6];
        if (sizeLegal(size2Code)) begin
          legal[17:16] = wrVal[17:16];
          if (XLEN == 64) legal[22:21] = wrVal[22:21];
        end
      end
      TY_ADDR6: begin
        legal[4:0]   = wrVal[4:0];
        legal[6]     = wrVal[6];
        legal[24:23] = wrVal[24:23];
        if (sizeLegal(wrVal[19:16])) legal[19:16] = wrVal[19:16];
      end
      TY_ICNT: begin
        legal[26:25] = wrVal[26:25];
        legal[23:10] = wrVal[23:10];
        legal[9]     = wrVal[9];
        legal[7:6]   = wrVal[7:6];
      end
      default: typeOk = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_csr_ctrl.sv
module trig_csr_ctrl
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 64
) (
  input  logic [2:0]      csrAddr,
  input  logic            csrWe,
  input  logic [XLEN-1:0] csrWdata,
  input  logic [3:0]      curType,
  output strobe_t         stb,
  output logic [XLEN-1:0] ctrlVal
);
  logic typeOk;
  logic selInRange;
  logic addrTypeOk;

  trig_legalize #(.XLEN(XLEN)) u_legal (
    .wrVal (csrWdata),
    .legal (ctrlVal),
    .typeOk(typeOk)
  );

  assign selInRange = csrWdata < XLEN'(NTRIG);
  assign addrTypeOk = (curType == TY_ADDR2) || (curType == TY_ADDR6);

  always_comb begin
    stb.selWr  = csrWe && (csrAddr == CSR_SELECT) && selInRange;
    stb.ctrlWr = csrWe && (csrAddr == CSR_CTRL) && typeOk;
    stb.addrWr = csrWe && (csrAddr == CSR_ADDR) && addrTypeOk;
  end
endmodule

// File: rtl/trig_csr_regs.sv
module trig_csr_regs
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [2:0]            csrAddr,
  input  logic [XLEN-1:0]       csrWdata,
  input  logic [XLEN-1:0]       ctrlVal,
  output logic [XLEN-1:0]       csrRdata,
  output logic [3:0]            curType,
  output logic [NTRIG*XLEN-1:0] trigCtrl,
  output logic [NTRIG*XLEN-1:0] trigAddr
);
  localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam logic [XLEN-1:0] RESET_CTRL = {TY_ADDR2, {(XLEN-4){1'b0}}};
  localparam logic [XLEN-1:0] CAPS_WORD  = XLEN'(68);

  logic [IDXW-1:0] sel;
  logic [XLEN-1:0] ctrlReg [NTRIG];
  logic [XLEN-1:0] addrReg [NTRIG];
  logic [XLEN-1:0] curCtrl;
  logic [XLEN-1:0] curAddr;

  always_ff @(posedge clk) begin
    if (!rstN)          sel <= '0;
    else if (stb.selWr) sel <= csrWdata[IDXW-1:0];
  end

  generate
    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ctrlReg[g] <= RESET_CTRL;
          addrReg[g] <= '0;
        end else begin
          if (stb.ctrlWr && sel == IDXW'(g)) ctrlReg[g] <= ctrlVal;
          if (stb.addrWr && sel == IDXW'(g)) addrReg[g] <= csrWdata;
        end
      end
      assign trigCtrl[g*XLEN +: XLEN] = ctrlReg[g];
      assign trigAddr[g*XLEN +: XLEN] = addrReg[g];
    end
  endgenerate

  assign curCtrl = ctrlReg[sel];
  assign curAddr = addrReg[sel];
  assign curType = curCtrl[XLEN-1 -: 4];

  always_comb begin
    case (csrAddr)
      CSR_SELECT: csrRdata = XLEN'(sel);
      CSR_CTRL:   csrRdata = curCtrl;
      CSR_ADDR:   csrRdata = curAddr;
      CSR_CAPS:   csrRdata = CAPS_WORD;
      default:    csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            csrAddr,
  input  logic                  csrWe,
  input  logic [XLEN-1:0]       csrWdata,
  output logic [XLEN-1:0]       csrRdata,
  output logic [NTRIG*XLEN-1:0] trigCtrl,
  output logic [NTRIG*XLEN-1:0] trigAddr
);
  strobe_t         stb;
  logic [XLEN-1:0] ctrlVal;
  logic [3:0]      curType;

  trig_csr_ctrl #(.NTRIG(NTRIG), .XLEN(XLEN)) u_ctrl (
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .csrWdata(csrWdata),
    .curType (curType),
    .stb     (stb),
    .ctrlVal (ctrlVal)
  );

  trig_csr_regs #(.NTRIG(NTRIG), .XLEN(XLEN)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .csrAddr (csrAddr),
    .csrWdata(csrWdata),
    .ctrlVal (ctrlVal),
    .csrRdata(csrRdata),
    .curType (curType),
    .trigCtrl(trigCtrl),
    .trigAddr(trigAddr)
  );
endmodule

// File: rtl/trig_csr_chk.sv
module trig_csr_chk
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 4,
  parameter int XLEN  = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2:0]            csrAddr,
  input logic                  csrWe,
  input logic [XLEN-1:0]       csrWdata,
  input logic [XLEN-1:0]       csrRdata,
  input logic [NTRIG*XLEN-1:0] trigCtrl,
  input logic [NTRIG*XLEN-1:0] trigAddr
);
  logic [3:0] wrType;
  logic       badType;
  assign wrType  = csrWdata[XLEN-1 -: 4];
  assign badType = !(wrType == TY_ADDR2 || wrType == TY_ICNT || wrType == TY_ADDR6);

  // R9
  aux_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == CSR_AUX) |-> (csrRdata == '0));

  // R10
  caps_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == CSR_CAPS) |-> (csrRdata == XLEN'(68)));

  // R11
  bad_type_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrAddr == CSR_CTRL && badType) |=> ($stable(trigCtrl) && $stable(trigAddr)));

  // R9
  aux_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrAddr == CSR_AUX) |=> ($stable(trigCtrl) && $stable(trigAddr)));

  generate
    for (genvar g = 0; g < NTRIG; g++) begin : g_chk
      // R3
      dmode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        trigCtrl[g*XLEN + XLEN - 5] == 1'b0);
      // R3
      stored_type_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
        (trigCtrl[g*XLEN + XLEN - 1 -: 4] == TY_ADDR2) ||
        (trigCtrl[g*XLEN + XLEN - 1 -: 4] == TY_ICNT) ||
        (trigCtrl[g*XLEN + XLEN - 1 -: 4] == TY_ADDR6));
    end
  endgenerate
endmodule

bind trig_csr_bank trig_csr_chk #(.NTRIG(NTRIG), .XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csrAddr (csrAddr),
  .csrWe   (csrWe),
  .csrWdata(csrWdata),
  .csrRdata(csrRdata),
  .trigCtrl(trigCtrl),
  .trigAddr(trigAddr)
);

// File: tb/tb_trig_csr_bank.sv
`timescale 1ns/1ps
module tb_trig_csr_bank;
  localparam int NTRIG = 4;
  localparam int XLEN  = 64;
  localparam logic [63:0] T2 = 64'h2000_0000_0000_0000;

  typedef struct packed {
    logic [7:0]  req;
    logic [63:0] wr;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{8'd3,  64'h2FFF_FFFF_FFFF_FFFF, 64'h2000_0000_0000_005F}, // R3 all set, code 15
    '{8'd5,  64'h2000_0000_0021_0044, 64'h2000_0000_0021_0044}, // R5 code 5 uses high bits
    '{8'd4,  64'h2000_0000_0020_0009, 64'h2000_0000_0000_0009}, // R4 code 4 illegal
    '{8'd3,  64'h2000_0000_001F_FF82, 64'h2000_0000_0003_0002}, // R3 droppable fields
    '{8'd6,  64'h6000_0000_01D5_0024, 64'h6000_0000_0185_0004}, // R6 code 5 kept
    '{8'd6,  64'h6000_0000_0006_0011, 64'h6000_0000_0000_0011}, // R6 code 6 illegal
    '{8'd6,  64'h6000_0000_000F_0040, 64'h6000_0000_0000_0040}, // R6 code 15 illegal
    '{8'd7,  64'h3800_0000_0700_17FF, 64'h3000_0000_0600_16C0}, // R7 count fields
    '{8'd3,  64'h2000_0000_0000_0000, 64'h2000_0000_0000_0000}, // R3 plain type 2
    '{8'd11, 64'h5000_0000_0000_0044, 64'h2000_0000_0000_0000}, // R11 type 5
    '{8'd11, 64'hF000_0000_0000_0007, 64'h2000_0000_0000_0000}  // R11 type 15
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] csrAddr = 3'd0;
  logic csrWe = 1'b0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic [NTRIG*64-1:0] trigCtrl, trigAddr;

  logic [2:0] c32Addr = 3'd0;
  logic c32We = 1'b0;
  logic [31:0] c32Wdata = '0;
  logic [31:0] c32Rdata;
  logic [NTRIG*32-1:0] c32Ctrl, c32Taddr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_csr_bank #(.NTRIG(NTRIG), .XLEN(XLEN)) dut (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .trigCtrl(trigCtrl), .trigAddr(trigAddr));

  trig_csr_bank #(.NTRIG(NTRIG), .XLEN(32)) dut32 (
    .clk(clk), .rstN(rstN), .csrAddr(c32Addr), .csrWe(c32We), .csrWdata(c32Wdata),
    .csrRdata(c32Rdata), .trigCtrl(c32Ctrl), .trigAddr(c32Taddr));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    csrAddr = a;
    #1;
    d = csrRdata;
  endtask

  task automatic wr32(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    c32Addr = a; c32Wdata = d; c32We = 1'b1;
    @(negedge clk);
    c32We = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(3'd0, v); check("R2 pointer", v, 64'd0);
    for (int i = 0; i < NTRIG; i++) begin
      wr(3'd0, 64'(i));
      rd(3'd1, v); check("R2 ctrl", v, T2);
      rd(3'd2, v); check("R2 addr", v, 64'd0);
      rd(3'd3, v); check("R2 aux", v, 64'd0);
    end
    check("R2 addr bus", trigAddr, '0);

    // R10 capability
    rd(3'd4, v); check("R10 caps", v, 64'h44);
    wr(3'd4, 64'hFFFF);
    rd(3'd4, v); check("R10 caps after write", v, 64'h44);
    rd(3'd6, v); check("R10 unused address reads zero", v, 64'd0);

    // legalization table on trigger 0 (R3 R4 R5 R6 R7 R11)
    wr(3'd0, 64'd0);
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd1, VEC[i].wr);
      rd(3'd1, v);
      nChecks++;
      if (v !== VEC[i].exp) begin
        nFails++;
        $display("FAIL R%0d table %0d: actual %h expected %h", VEC[i].req, i, v, VEC[i].exp);
      end
    end

    // R1 pointer range
    wr(3'd0, 64'd2); rd(3'd0, v); check("R1 in range", v, 64'd2);
    wr(3'd0, 64'd4); rd(3'd0, v); check("R1 equal NTRIG ignored", v, 64'd2);
    wr(3'd0, 64'h1_0000_0001); rd(3'd0, v); check("R1 truncating value ignored", v, 64'd2);
    wr(3'd0, 64'd3); rd(3'd0, v); check("R1 top index", v, 64'd3);

    // R8 R11 on trigger 3
    wr(3'd2, 64'h0000_1234_5678_9ABC);
    rd(3'd2, v); check("R8 addr stored type2", v, 64'h0000_1234_5678_9ABC);
    check("R12 addr bus slice", trigAddr[3*64 +: 64], 64'h0000_1234_5678_9ABC);
    wr(3'd1, 64'h4000_0000_0000_0007);
    rd(3'd1, v); check("R11 ctrl unchanged", v, T2);
    rd(3'd2, v); check("R11 addr unchanged", v, 64'h0000_1234_5678_9ABC);
    wr(3'd1, 64'h3000_0000_0000_0400);
    rd(3'd1, v); check("R7 count one", v, 64'h3000_0000_0000_0400);
    wr(3'd2, 64'h2000_0000_0000_0BAD);
    rd(3'd2, v); check("R8 addr ignored type3", v, 64'h0000_1234_5678_9ABC);
    wr(3'd1, 64'h6000_0000_0000_0004);
    wr(3'd2, 64'h0000_0000_CAFE_0000);
    rd(3'd2, v); check("R8 addr stored type6", v, 64'h0000_0000_CAFE_0000);

    // R9 auxiliary
    wr(3'd3, 64'hFF);
    rd(3'd3, v); check("R9 aux ignored", v, 64'd0);
    rd(3'd2, v); check("R9 addr untouched", v, 64'h0000_0000_CAFE_0000);

    // R12 per-trigger export
    wr(3'd0, 64'd1);
    wr(3'd1, 64'h6000_0000_0000_0045);
    check("R12 ctrl slice 1", trigCtrl[1*64 +: 64], 64'h6000_0000_0000_0045);
    check("R12 ctrl slice 0", trigCtrl[0 +: 64], T2);
    check("R12 ctrl slice 2", trigCtrl[2*64 +: 64], T2);
    check("R12 ctrl slice 3", trigCtrl[3*64 +: 64], 64'h6000_0000_0000_0004);

    // R5 narrow instance
    wr32(3'd1, 32'h2061_0004);
    c32Addr = 3'd1; #1;
    check("R5 narrow drops high size", 64'(c32Rdata), 64'h2001_0004);
    wr32(3'd1, 32'h2800_0004);
    c32Addr = 3'd1; #1;
    check("R3 narrow dmode cleared", 64'(c32Rdata), 64'h2000_0004);
    check("R12 narrow slice", 64'(c32Ctrl[0 +: 32]), 64'h2000_0004);

    done = 1'b1;
    summary();
  end
endmodule